// File: doc/BRIEF.md
# Duty-Cycled Magnetic Switch Wake Sequencer

This block schedules the short measurement bursts of a low-power sampled magnetic switch sensor. It runs from a single system clock and advances only on two tick-enable inputs. A slow tick, about 8 kHz, times the long sleep interval. A fast tick, about 100 kHz, times the awake burst. After a programmable number of slow ticks it raises an awake enable that powers the analog front end and selects the fast timebase. It then runs a fixed train of three phases: a reset phase, a first measurement phase and a second measurement phase. After that it drops back to sleep.

During both measurement phases the block drives two active-low sensing-orientation switch clocks and their true-polarity copies. The two orientations alternate on every fast tick, which gives a rate of half the fast tick. At least one system clock of dead time separates them, so both are never low together. The first measurement phase opens the comparator autozero window. A one-cycle compare-valid strobe marks the closing fast tick of the second measurement phase. A force-awake input chains bursts back to back for current measurement.

With the defaults, one burst is 5 fast ticks (about 50 us). The sleep interval is 400 slow ticks (about 50 ms), so the awake fraction is near one thousandth.

Top module: `hall_wake_seq`

## Requirements
- R1: While and after reset, `phase` is 0 (sleep), `awake_en` is 0, both switch clocks `sw0_n`/`sw1_n` are high, `sw0`/`sw1` are low, and `az_win` and `cmp_valid` are 0.
- R2: From the start of a sleep interval without force-awake, `awake_en` stays low through SLEEP_TICKS-1 slow ticks. It rises in the cycle after the clock edge that samples the SLEEP_TICKS-th slow tick.
- R3: `phase` encodes 0 = sleep, 1 = reset phase, 2 = first measurement, 3 = second measurement. A burst runs 1, 2, 3 in that order. The reset phase lasts RST_TICKS fast ticks and each measurement phase lasts MEAS_TICKS fast ticks. After phase 3 the block returns to 0.
- R4: `awake_en` is high exactly while `phase` is not 0.
- R5: A fast tick has no effect while asleep, and a slow tick has no effect while awake.
- R6: Switch clocks are active low. `sw0_n` low selects the first orientation and `sw1_n` low the second. Each measurement phase begins with the first orientation, and the active orientation swaps on every fast tick. `sw0`/`sw1` are always the inverses of `sw0_n`/`sw1_n`.
- R7: `sw0_n` and `sw1_n` are never low together. The first cycle of each measurement phase, and the cycle after every fast tick inside one, has both high.
- R8: `az_win` is high exactly during phase 2.
- R9: `cmp_valid` is high for one cycle only: the phase-3 cycle that carries that phase's last fast tick.
- R10: In sleep and in the reset phase, both switch clocks are high and `az_win` and `cmp_valid` are low.
- R11: With `force_awake` high in sleep, phase 1 follows in the next cycle. With it high at the end of phase 3, phase 1 follows instead of sleep.
- R12: The sleep count restarts from zero on every sleep interval, even after a partial count was cut short by force-awake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_fast | input | 1 | One-cycle enable at the awake timebase rate |
| tick_slow | input | 1 | One-cycle enable at the sleep timebase rate |
| force_awake | input | 1 | Keep running bursts back to back |
| awake_en | output | 1 | Front-end enable and fast-timebase select |
| phase | output | 2 | Current phase (0 sleep, 1 reset, 2 measure 1, 3 measure 2) |
| sw0_n | output | 1 | First-orientation switch clock, active low |
| sw0 | output | 1 | Inverse of sw0_n |
| sw1_n | output | 1 | Second-orientation switch clock, active low |
| sw1 | output | 1 | Inverse of sw1_n |
| az_win | output | 1 | Comparator autozero / sample window |
| cmp_valid | output | 1 | One-cycle compare-valid strobe |

## Verification
A sleep count that is off by one, or that is not cleared, shows up as `awake_en` rising a slow tick early or late. That is visible at the first wake after the fault. A phase counter fault stretches or shortens a phase by a fast tick, and `phase` exposes it on the cycle of the mistaken transition. A wrong orientation register shows on the first non-dead cycle of a measurement phase, because the wrong switch clock goes low there. A missing dead cycle shows as an immediate handover between `sw0_n` and `sw1_n`.

// File: rtl/hws_pkg.sv
package hws_pkg;

  typedef enum logic [1:0] {
    PH_SLEEP = 2'd0,
    PH_RST   = 2'd1,
    PH_MEAS1 = 2'd2,
    PH_MEAS2 = 2'd3
  } phase_e;

endpackage

// File: rtl/hws_sleep_timer.sv
module hws_sleep_timer #(
  parameter int SLEEP_TICKS = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic tick,
  output logic expire
);

  localparam int CW = (SLEEP_TICKS > 1) ? $clog2(SLEEP_TICKS + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLEEP_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    expire = run && tick && (cnt_q == LAST);
    cnt_d  = cnt_q;
    if (clr || !run) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_SLEEP_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2

  AST_SLEEP_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0); // R12

endmodule

// File: rtl/hws_phase_seq.sv
module hws_phase_seq
  import hws_pkg::*;
#(
  parameter int RST_TICKS  = 1,
  parameter int MEAS_TICKS = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick_fast,
  input  logic   wake,
  input  logic   force_awake,
  output phase_e phase,
  output logic   ph_end,
  output logic   leave_sleep,
  output logic   cmp_valid
);

  localparam int PMAX = (RST_TICKS > MEAS_TICKS) ? RST_TICKS : MEAS_TICKS;
  localparam int PW   = (PMAX > 1) ? $clog2(PMAX + 1) : 1;
  localparam logic [PW-1:0] RST_LAST  = PW'(RST_TICKS - 1);
  localparam logic [PW-1:0] MEAS_LAST = PW'(MEAS_TICKS - 1);

  phase_e        ph_q, ph_d;
  logic [PW-1:0] pc_q, pc_d;
  logic [PW-1:0] lim;

  always_comb begin
    lim         = (ph_q == PH_RST) ? RST_LAST : MEAS_LAST;
    ph_end      = (ph_q != PH_SLEEP) && tick_fast && (pc_q == lim);
    leave_sleep = (ph_q == PH_SLEEP) && (wake || force_awake);
    cmp_valid   = ph_end && (ph_q == PH_MEAS2);

    ph_d = ph_q;
    unique case (ph_q)
      PH_SLEEP: if (leave_sleep) ph_d = PH_RST;
      PH_RST:   if (ph_end)      ph_d = PH_MEAS1;
      PH_MEAS1: if (ph_end)      ph_d = PH_MEAS2;
      PH_MEAS2: if (ph_end)      ph_d = force_awake ? PH_RST : PH_SLEEP;
      default:                   ph_d = PH_SLEEP;
    endcase

    pc_d = pc_q;
    if ((ph_q == PH_SLEEP) || ph_end) begin
      pc_d = '0;
    end else if (tick_fast) begin
      pc_d = pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_SLEEP;
      pc_q <= '0;
    end else begin
      ph_q <= ph_d;
      pc_q <= pc_d;
    end
  end

  assign phase = ph_q;

  AST_ORDER_FROM_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RST) |=> (ph_q inside {PH_RST, PH_MEAS1})); // R3

  AST_ORDER_FROM_MEAS1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_MEAS1) |=> (ph_q inside {PH_MEAS1, PH_MEAS2})); // R3

  AST_ORDER_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SLEEP) |=> (ph_q inside {PH_SLEEP, PH_RST})); // R3

  AST_PC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= lim); // R3

  AST_VALID_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> (ph_q != PH_MEAS2)); // R9

endmodule

// File: rtl/hws_spin_clk.sv
module hws_spin_clk (
  input  logic clk,
  input  logic rst_n,
  input  logic meas,
  input  logic restart,
  input  logic tick,
  output logic sw0_n,
  output logic sw0,
  output logic sw1_n,
  output logic sw1
);

  logic sel_q, sel_d;
  logic dead_q, dead_d;
  logic act0, act1;

  always_comb begin
    sel_d  = sel_q;
    dead_d = 1'b0;
    if (!meas || restart) begin
      sel_d  = 1'b0;
      dead_d = 1'b1;
    end else if (tick) begin
      sel_d  = ~sel_q;
      dead_d = 1'b1;
    end
    act0 = meas && !dead_q && !sel_q;
    act1 = meas && !dead_q &&  sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      dead_q <= 1'b1;
    end else begin
      sel_q  <= sel_d;
      dead_q <= dead_d;
    end
  end

  assign sw0_n = ~act0;
  assign sw0   =  act0;
  assign sw1_n = ~act1;
  assign sw1   =  act1;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    sw0_n || sw1_n); // R7

  AST_GAP_INTO_1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw1_n) |-> $past(sw0_n)); // R7

  AST_GAP_INTO_0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw0_n) |-> $past(sw1_n)); // R7

  AST_ENTRY_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas) |-> (sw0_n && sw1_n)); // R7

endmodule

// File: rtl/hall_wake_seq.sv
module hall_wake_seq
  import hws_pkg::*;
#(
  parameter int SLEEP_TICKS = 400,
  parameter int RST_TICKS   = 1,
  parameter int MEAS_TICKS  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_fast,
  input  logic       tick_slow,
  input  logic       force_awake,
  output logic       awake_en,
  output logic [1:0] phase,
  output logic       sw0_n,
  output logic       sw0,
  output logic       sw1_n,
  output logic       sw1,
  output logic       az_win,
  output logic       cmp_valid
);

  phase_e ph;
  logic   sleeping;
  logic   tmr_expire;
  logic   leave_sleep;
  logic   ph_end;
  logic   meas;
  logic   meas1_end;

  assign sleeping  = (ph == PH_SLEEP);
  assign meas      = (ph == PH_MEAS1) || (ph == PH_MEAS2);
  assign meas1_end = ph_end && (ph == PH_MEAS1);

  hws_sleep_timer #(
    .SLEEP_TICKS(SLEEP_TICKS)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (sleeping),
    .clr    (leave_sleep),
    .tick   (tick_slow),
    .expire (tmr_expire)
  );

  hws_phase_seq #(
    .RST_TICKS (RST_TICKS),
    .MEAS_TICKS(MEAS_TICKS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_fast   (tick_fast),
    .wake        (tmr_expire),
    .force_awake (force_awake),
    .phase       (ph),
    .ph_end      (ph_end),
    .leave_sleep (leave_sleep),
    .cmp_valid   (cmp_valid)
  );

  hws_spin_clk u_spin (
    .clk     (clk),
    .rst_n   (rst_n),
    .meas    (meas),
    .restart (meas1_end),
    .tick    (tick_fast),
    .sw0_n   (sw0_n),
    .sw0     (sw0),
    .sw1_n   (sw1_n),
    .sw1     (sw1)
  );

  assign awake_en = !sleeping;
  assign phase    = ph;
  assign az_win   = (ph == PH_MEAS1);

  AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awake_en) |-> ($past(force_awake) || $past(tick_slow))); // R2

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> !cmp_valid); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !meas |-> (sw0_n && sw1_n && !cmp_valid)); // R10

  AST_AZ_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    az_win |-> awake_en); // R8

endmodule

// File: tb/hall_wake_seq_bench.sv
module hall_wake_seq_bench;

  localparam int ST = 7;
  localparam int RT = 2;
  localparam int MT = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic tick_fast = 1'b0, tick_slow = 1'b0, force_awake = 1'b0;
  logic awake_en, sw0_n, sw0, sw1_n, sw1, az_win, cmp_valid;
  logic [1:0] phase;

  hall_wake_seq #(.SLEEP_TICKS(ST), .RST_TICKS(RT), .MEAS_TICKS(MT)) u_hall_wake_seq (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .force_awake(force_awake), .awake_en(awake_en), .phase(phase),
    .sw0_n(sw0_n), .sw0(sw0), .sw1_n(sw1_n), .sw1(sw1),
    .az_win(az_win), .cmp_valid(cmp_valid));

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;
  bit  run_chk = 0;

  // expectation model built from the requirements
  int m_ph, m_cnt, m_pc;
  bit m_sel, m_dead, m_last, m_meas;

  function automatic int lim_of(int ph);
    return (ph == 1) ? RT : MT;
  endfunction

  always_comb begin
    m_meas = (m_ph >= 2);
    m_last = (m_ph != 0) && tick_fast && (m_pc == lim_of(m_ph) - 1);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_cnt <= 0; m_pc <= 0; m_sel <= 0; m_dead <= 1;
    end else begin
      if (!m_meas || m_last) begin m_sel <= 0; m_dead <= 1; end
      else if (tick_fast) begin m_sel <= !m_sel; m_dead <= 1; end
      else m_dead <= 0;
      if (m_ph == 0) begin
        if (force_awake || (tick_slow && m_cnt == ST - 1)) begin m_ph <= 1; m_cnt <= 0; end
        else if (tick_slow) m_cnt <= m_cnt + 1;
      end else begin
        if (m_last) begin
          m_pc <= 0;
          m_ph <= (m_ph == 3) ? (force_awake ? 1 : 0) : m_ph + 1;
        end else if (tick_fast) m_pc <= m_pc + 1;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (run_chk && rst_n && !done) begin
      #1;
      chk("R3 phase", phase, m_ph);
      chk("R4 awake_en", awake_en, m_ph != 0);
      chk("R6 sw0_n", sw0_n, !(m_meas && !m_dead && !m_sel));
      chk("R6 sw1_n", sw1_n, !(m_meas && !m_dead && m_sel));
      chk("R6 sw0 inverse", sw0, !sw0_n);
      chk("R6 sw1 inverse", sw1, !sw1_n);
      chk("R7 no overlap", sw0_n || sw1_n, 1);
      chk("R8 az_win", az_win, m_ph == 2);
      chk("R9 cmp_valid", cmp_valid, m_last && m_ph == 3);
    end
  end

  task automatic pulse_slow();
    @(negedge clk) tick_slow = 1'b1;
    @(negedge clk) tick_slow = 1'b0;
  endtask

  task automatic pulse_fast();
    @(negedge clk) tick_fast = 1'b1;
    @(negedge clk) tick_fast = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    chk("R1 phase", phase, 0);
    chk("R1 awake_en", awake_en, 0);
    chk("R1 sw0_n/sw1_n", {sw0_n, sw1_n}, 3);
    chk("R1 sw0/sw1", {sw0, sw1}, 0);
    chk("R1 az/valid", {az_win, cmp_valid}, 0);
    @(negedge clk) rst_n = 1'b1;
    run_chk = 1;
    #2;
    chk("R1 after release", {awake_en, sw0_n, sw1_n, az_win, cmp_valid}, 5'b01100);

    // R2: exact sleep length
    repeat (ST - 1) pulse_slow();
    #2 chk("R2 still asleep", awake_en, 0);
    pulse_slow();
    #2 chk("R2 wake", awake_en, 1);
    chk("R2 reset phase", phase, 1);

    // R10 and R5: reset phase is quiet, slow ticks ignored while awake
    repeat (3) pulse_slow();
    #2 chk("R5 slow tick ignored awake", phase, 1);
    chk("R10 quiet in reset phase", {sw0_n, sw1_n, az_win, cmp_valid}, 4'b1100);
    repeat (RT + 2 * MT) pulse_fast();
    #2 chk("R3 back to sleep", phase, 0);

    // R5: fast ticks ignored in sleep
    repeat (5) pulse_fast();
    #2 chk("R5 fast tick ignored asleep", phase, 0);
    chk("R10 quiet in sleep", {sw0_n, sw1_n, az_win, cmp_valid}, 4'b1100);

    // R12: partial count, forced wake, full recount afterwards
    repeat (ST - 2) pulse_slow();
    @(negedge clk) force_awake = 1'b1;
    @(negedge clk) force_awake = 1'b0;
    #2 chk("R11 forced wake", phase, 1);
    repeat (RT + 2 * MT) pulse_fast();
    #2 chk("R12 sleep after forced burst", phase, 0);
    repeat (ST - 1) pulse_slow();
    #2 chk("R12 count restarted", awake_en, 0);
    pulse_slow();
    #2 chk("R12 full count wakes", awake_en, 1);

    // R11: chained bursts under force_awake
    @(negedge clk) force_awake = 1'b1;
    repeat (RT + 2 * MT) pulse_fast();
    #2 chk("R11 chained burst", phase, 1);
    @(negedge clk) force_awake = 1'b0;
    repeat (RT + 2 * MT) pulse_fast();
    #2 chk("R11 release to sleep", phase, 0);

    // random phase
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      tick_fast = ($urandom_range(0, 3) == 0);
      tick_slow = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 199) == 0) force_awake = !force_awake;
    end
    @(negedge clk);
    tick_fast = 0; tick_slow = 0; force_awake = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule